// File: doc/BRIEF.md
# Power Domain State Controller

This block manages the power state of one switchable group of logic. It follows the group through four conditions: powered with some clock domain running, powered with every clock domain idle, close-switch retention with clocks gated, and fully off. Software names a target condition. The controller then carries out the whole transition itself. It drives the logic power-switch enable, the domain clock-gate enable, a one-cycle retention-save strobe and a two-bit status word.

Before the domain can be switched off, its context must be copied to an always-on scratchpad. When the domain is powered up again, the context must be copied back. Both copies are modelled as request/acknowledge handshakes with an external store.

A low-power target does not take effect at once. It is held pending until every enclosed clock domain reports idle. A pending target is cancelled by a later power-on target. The domain leaves retention either on a wake request or when any clock domain becomes active again.

Top module: `pdom_ctrl`

## Requirements
- R1: After synchronous reset the domain is powered (`pwr_sw_en`=1) and clocked (`clk_en`=1). No handshake request and no retention strobe is active, and `status` reads 2'b11.
- R2: While powered and running, `status` is 2'b10 if every bit of `cd_idle` was 1 at the previous clock edge, and 2'b11 otherwise. Status codes are: 2'b00 off, 2'b01 retention, 2'b10 on-idle, 2'b11 on-active.
- R3: A target request (`tgt_valid` with `tgt_code`) uses these codes: 2'b00 off, 2'b01 retention, 2'b1x on. A low-power target is held pending and not acted on while any `cd_idle` bit is 0. It takes effect two edges after all idle inputs rise.
- R4: On entry to retention, `clk_en` falls and `pwr_sw_en` stays 1. `status` becomes 2'b01, and `ret_save` is high for exactly the first retention cycle.
- R5: In retention, an on target or any `cd_idle` bit at 0 causes one ungate cycle. In that cycle `clk_en`=1 and `status`=2'b01. The domain is back on at the next edge.
- R6: On entry to off, `save_req` rises with clocks gated and power still on. `save_req` stays high until `save_ack` is seen. Only then does `pwr_sw_en` fall and `status` become 2'b00.
- R7: From off, an on target closes the power switch at once. After exactly SETTLE_CYC cycles `rest_req` rises and stays high until `rest_ack`. The domain then reports on with `clk_en`=1.
- R8: Low-power targets received while the domain is off, settling or restoring are discarded. An on target cancels any pending low-power target.
- R9: `clk_en` is never 1 while `pwr_sw_en` is 0, and `save_req` and `rest_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | Target request strobe |
| tgt_code | input | 2 | Requested target condition |
| cd_idle | input | NUM_CD | Idle flag from each enclosed clock domain |
| save_ack | input | 1 | Scratchpad save complete |
| rest_ack | input | 1 | Scratchpad restore complete |
| pwr_sw_en | output | 1 | Logic power switch closed |
| clk_en | output | 1 | Domain clock gate enable |
| ret_save | output | 1 | Retention-save strobe |
| save_req | output | 1 | Context save request |
| rest_req | output | 1 | Context restore request |
| status | output | 2 | Current condition code |

## Verification
The bench issues a retention request while one clock domain is still busy. A controller that ignores the idle condition would gate clocks early; one that drops the request would never enter retention.

It leaves retention twice, once by request and once by clock-domain activity. This catches a design that skips the ungate cycle or wakes on only one of the two causes.

During entry to off, the acknowledge is withheld for several cycles, which exposes early power removal. During exit from off, the bench counts the settle window cycle by cycle to catch an off-by-one in the timer.

Stale low-power requests, both discarded and cancelled, are checked by watching that the status stays on-idle afterwards. Random idle patterns check the status encoding.

// File: rtl/pdom_pkg.sv
package pdom_pkg;

    typedef enum logic [2:0] {
        PS_ON      = 3'd0,
        PS_WAKE    = 3'd1,
        PS_RET     = 3'd2,
        PS_SAVE    = 3'd3,
        PS_OFF     = 3'd4,
        PS_SETTLE  = 3'd5,
        PS_RESTORE = 3'd6
    } pstate_e;

    typedef enum logic [1:0] {
        STAT_OFF  = 2'b00,
        STAT_RET  = 2'b01,
        STAT_IDLE = 2'b10,
        STAT_ACT  = 2'b11
    } pstat_e;

    typedef struct packed {
        logic pwr;
        logic clk;
        logic save;
        logic rest;
    } pctl_t;

    function automatic pstat_e status_of(pstate_e s, logic idle);
        case (s)
            PS_ON:                       return idle ? STAT_IDLE : STAT_ACT;
            PS_SAVE:                     return STAT_IDLE;
            PS_RET, PS_WAKE:             return STAT_RET;
            default:                     return STAT_OFF;
        endcase
    endfunction

    function automatic pctl_t ctl_of(pstate_e s);
        pctl_t c;
        c = '{pwr: 1'b1, clk: 1'b0, save: 1'b0, rest: 1'b0};
        case (s)
            PS_ON, PS_WAKE: c.clk  = 1'b1;
            PS_SAVE:        c.save = 1'b1;
            PS_OFF:         c.pwr  = 1'b0;
            PS_RESTORE:     c.rest = 1'b1;
            default:        ;
        endcase
        return c;
    endfunction

    function automatic logic lp_accepted(pstate_e s);
        return (s == PS_ON) || (s == PS_WAKE) || (s == PS_RET) || (s == PS_SAVE);
    endfunction

endpackage

// File: rtl/pdom_idle_mon.sv
module pdom_idle_mon #(
    parameter int NUM_CD = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CD-1:0] cd_idle,
    output logic              all_idle
);
    always_ff @(posedge clk) begin
        if (rst) all_idle <= 1'b0;
        else     all_idle <= &cd_idle;
    end
endmodule

// File: rtl/pdom_pend.sv
module pdom_pend (
    input  logic       clk,
    input  logic       rst,
    input  logic       tgt_valid,
    input  logic [1:0] tgt_code,
    input  logic       accept_lp,
    input  logic       consume,
    output logic       pend_valid,
    output logic       pend_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_off   <= 1'b0;
        end else if (tgt_valid && tgt_code[1]) begin
            pend_valid <= 1'b0;
        end else if (tgt_valid && accept_lp) begin
            pend_valid <= 1'b1;
            pend_off   <= ~tgt_code[0];
        end else if (consume) begin
            pend_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pdom_settle_tmr.sv
module pdom_settle_tmr #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LOADV = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (start)            cnt <= LOADV;
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pdom_fsm.sv
module pdom_fsm
    import pdom_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   all_idle,
    input  logic   pend_valid,
    input  logic   pend_off,
    input  logic   wake_req,
    input  logic   save_ack,
    input  logic   rest_ack,
    input  logic   settle_done,
    output pstate_e state,
    output logic   consume,
    output logic   tmr_start,
    output logic   ret_save
);
    pstate_e nxt;

    always_comb begin
        nxt       = state;
        consume   = 1'b0;
        tmr_start = 1'b0;
        case (state)
            PS_ON: if (pend_valid && all_idle) begin
                nxt     = pend_off ? PS_SAVE : PS_RET;
                consume = 1'b1;
            end
            PS_RET:     if (wake_req || !all_idle) nxt = PS_WAKE;
            PS_WAKE:    nxt = PS_ON;
            PS_SAVE:    if (save_ack) nxt = PS_OFF;
            PS_OFF: if (wake_req) begin
                nxt       = PS_SETTLE;
                tmr_start = 1'b1;
            end
            PS_SETTLE:  if (settle_done) nxt = PS_RESTORE;
            PS_RESTORE: if (rest_ack) nxt = PS_ON;
            default:    nxt = PS_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_ON;
            ret_save <= 1'b0;
        end else begin
            state    <= nxt;
            ret_save <= (state == PS_ON) && (nxt == PS_RET);
        end
    end
endmodule

// File: rtl/pdom_ctrl.sv
module pdom_ctrl
    import pdom_pkg::*;
#(
    parameter int NUM_CD     = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tgt_valid,
    input  logic [1:0]        tgt_code,
    input  logic [NUM_CD-1:0] cd_idle,
    input  logic              save_ack,
    input  logic              rest_ack,
    output logic              pwr_sw_en,
    output logic              clk_en,
    output logic              ret_save,
    output logic              save_req,
    output logic              rest_req,
    output logic [1:0]        status
);
    logic    all_idle, pend_valid, pend_off, consume, tmr_start, settle_done;
    pstate_e state;
    pctl_t   ctl;

    pdom_idle_mon #(.NUM_CD(NUM_CD)) u_idle (
        .clk(clk), .rst(rst), .cd_idle(cd_idle), .all_idle(all_idle)
    );

    pdom_pend u_pend (
        .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_code(tgt_code),
        .accept_lp(lp_accepted(state)), .consume(consume),
        .pend_valid(pend_valid), .pend_off(pend_off)
    );

    pdom_settle_tmr #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start(tmr_start),
        .run(state == PS_SETTLE), .done(settle_done)
    );

    pdom_fsm u_fsm (
        .clk(clk), .rst(rst), .all_idle(all_idle),
        .pend_valid(pend_valid), .pend_off(pend_off),
        .wake_req(tgt_valid && tgt_code[1]),
        .save_ack(save_ack), .rest_ack(rest_ack), .settle_done(settle_done),
        .state(state), .consume(consume), .tmr_start(tmr_start), .ret_save(ret_save)
    );

    assign ctl       = ctl_of(state);
    assign pwr_sw_en = ctl.pwr;
    assign clk_en    = ctl.clk;
    assign save_req  = ctl.save;
    assign rest_req  = ctl.rest;
    assign status    = status_of(state, all_idle);
endmodule

// File: rtl/pdom_ctrl_chk.sv
module pdom_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_sw_en,
    input logic       clk_en,
    input logic       ret_save,
    input logic       save_req,
    input logic       save_ack,
    input logic       rest_req,
    input logic [1:0] status
);
    AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> pwr_sw_en); // R9
    AST_HSK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(save_req && rest_req)); // R9
    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (save_req && !save_ack) |=> save_req); // R6
    AST_PWR_OFF_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_sw_en) |-> $past(save_req && save_ack)); // R6
    AST_RETSAVE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ret_save |=> !ret_save); // R4
    AST_RETSAVE_GATED: assert property (@(posedge clk) disable iff (rst)
        ret_save |-> (status == 2'b01 && !clk_en && pwr_sw_en)); // R4
    AST_REST_POWERED: assert property (@(posedge clk) disable iff (rst)
        rest_req |-> (pwr_sw_en && status == 2'b00)); // R7
    AST_OFF_GATED: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00) |-> !clk_en); // R7
endmodule

bind pdom_ctrl pdom_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .pwr_sw_en(pwr_sw_en), .clk_en(clk_en),
    .ret_save(ret_save), .save_req(save_req), .save_ack(save_ack),
    .rest_req(rest_req), .status(status)
);

// File: tb/pdom_ctrl_bench.sv
`timescale 1ns/1ps
module pdom_ctrl_bench;
    localparam int NCD    = 4;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tgt_valid = 1'b0;
    logic [1:0] tgt_code = 2'b00;
    logic [NCD-1:0] cd_idle = '0;
    logic save_ack = 1'b0, rest_ack = 1'b0;
    logic pwr_sw_en, clk_en, ret_save, save_req, rest_req;
    logic [1:0] status;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pdom_ctrl #(.NUM_CD(NCD), .SETTLE_CYC(SETTLE)) u_pdom_ctrl (
        .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_code(tgt_code),
        .cd_idle(cd_idle), .save_ack(save_ack), .rest_ack(rest_ack),
        .pwr_sw_en(pwr_sw_en), .clk_en(clk_en), .ret_save(ret_save),
        .save_req(save_req), .rest_req(rest_req), .status(status)
    );

    function automatic logic [1:0] exp_on_status(logic [NCD-1:0] idle);
        return (&idle) ? 2'b10 : 2'b11;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [1:0] code);
        tgt_valid = 1'b1;
        tgt_code  = code;
        step();
        tgt_valid = 1'b0;
    endtask

    task automatic chk_inv();
        chk("R9 clk_en without power", 32'(clk_en && !pwr_sw_en), 0);
        chk("R9 both handshakes", 32'(save_req && rest_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 pwr", 32'(pwr_sw_en), 1);
        chk("R1 clk", 32'(clk_en), 1);
        chk("R1 reqs", {29'd0, ret_save, save_req, rest_req}, 0);
        chk("R1 status", 32'(status), 32'h3);

        // R2 directed
        cd_idle = 4'b1111; step();
        chk("R2 all idle", 32'(status), 32'h2);
        cd_idle = 4'b1110; step();
        chk("R2 one active", 32'(status), 32'h3);

        // R3 pending until idle
        cd_idle = 4'b0111; step();
        send(2'b01);
        repeat (3) step();
        chk("R3 held status", 32'(status), 32'h3);
        chk("R3 held clk", 32'(clk_en), 1);
        cd_idle = 4'b1111; step();
        chk("R3 idle seen", 32'(status), 32'h2);
        chk("R3 still clocked", 32'(clk_en), 1);
        step();
        // R4 retention entry
        chk("R4 status", 32'(status), 32'h1);
        chk("R4 clk gated", 32'(clk_en), 0);
        chk("R4 powered", 32'(pwr_sw_en), 1);
        chk("R4 strobe", 32'(ret_save), 1);
        step();
        chk("R4 strobe one cycle", 32'(ret_save), 0);

        // R5 wake by request
        send(2'b10);
        chk("R5 ungate clk", 32'(clk_en), 1);
        chk("R5 ungate status", 32'(status), 32'h1);
        step();
        chk("R5 back on", 32'(status), 32'h2);

        // R5 wake by activity
        send(2'b01);
        step();
        chk("R5 retention again", 32'(status), 32'h1);
        cd_idle = 4'b1011; step();
        chk("R5 still ret", 32'(clk_en), 0);
        step();
        chk("R5 act ungate", 32'(clk_en), 1);
        chk("R5 act ungate status", 32'(status), 32'h1);
        step();
        chk("R5 act on", 32'(status), 32'h3);

        // R6 off entry
        cd_idle = 4'b1111; step();
        send(2'b00);
        step();
        chk("R6 save_req", 32'(save_req), 1);
        chk("R6 clk gated", 32'(clk_en), 0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R6 wait ack power", 32'(pwr_sw_en), 1);
            chk("R6 wait ack req", 32'(save_req), 1);
        end
        save_ack = 1'b1; step(); save_ack = 1'b0;
        chk("R6 off power", 32'(pwr_sw_en), 0);
        chk("R6 off status", 32'(status), 32'h0);
        chk("R6 save done", 32'(save_req), 0);
        chk_inv();

        // R8 low-power request while off is discarded
        send(2'b01);
        repeat (3) step();
        chk("R8 off stays", 32'(status), 32'h0);

        // R7 power-up with settle count
        send(2'b10);
        chk("R7 switch closed", 32'(pwr_sw_en), 1);
        chk("R7 no restore yet", 32'(rest_req), 0);
        for (int i = 1; i < SETTLE; i++) begin
            step();
            chk("R7 settling", 32'(rest_req), 0);
        end
        step();
        chk("R7 restore req", 32'(rest_req), 1);
        chk_inv();
        repeat (2) step();
        chk("R7 restore hold", 32'(rest_req), 1);
        chk("R7 gated while restoring", 32'(clk_en), 0);
        rest_ack = 1'b1; step(); rest_ack = 1'b0;
        chk("R7 on clk", 32'(clk_en), 1);
        chk("R7 on status", 32'(status), 32'h2);
        repeat (4) step();
        chk("R8 discarded request", 32'(status), 32'h2);

        // R8 cancel by on target
        cd_idle = 4'b0000; step(); step();
        send(2'b01);
        send(2'b11);
        cd_idle = 4'b1111;
        repeat (4) step();
        chk("R8 cancelled status", 32'(status), 32'h2);
        chk("R8 cancelled clk", 32'(clk_en), 1);

        // R2 random idle patterns, occasional harmless on targets
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            cd_idle   = r[NCD-1:0];
            tgt_valid = (r[8:6] == 3'b000);
            tgt_code  = {1'b1, r[9]};
            step();
            tgt_valid = 1'b0;
            chk("R2 random status", 32'(status), 32'(exp_on_status(cd_idle)));
            if (i % 50 == 0) chk_inv();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule